// File: doc/BRIEF.md
# Input Frame Offset Measurement Unit

This unit finds how many half master-clock periods an input stream's frame boundary trails the system frame pulse. It also produces one sampling strobe per input stream, each pushed later by its own programmable delay. The unit runs on a clock at twice the master-clock rate, so one cycle of `clk` is one half-period step. All counts, delays and offsets below are in these steps.

The unit watches the idle level of the frame pulse and from it decides whether the system uses the active-low format or the active-high format. The edge that leaves the idle level is the reference edge. On the evaluation input, the same kind of edge is the measured event. A measurement is started by a register bit. The bit must stay low for a whole frame, then go high. Two frames later a completion flag rises and the 12-bit result is valid. A wide-frame mode select blocks measurement. The per-stream strobe delays still work in that mode.

Top module: `frame_offset_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, `done_o` is 0, `offset_o` is 0, `gci_o` is 0 and every `strobe_o` bit is 0.
- R2: Once `fp_i` has held one level for 8 consecutive cycles, that level becomes the idle level. `gci_o` is 1 when the idle level is 0 (active-high pulses, rising edges used) and 0 when the idle level is 1 (active-low pulses, falling edges used).
- R3: A rising edge of `start_i` begins a measurement only if `start_i` was sampled low on at least two reference edges before it. Otherwise the rise is ignored and `done_o` stays 0.
- R4: `done_o` goes to 1 in the cycle after the second reference edge that follows the sampled rise of `start_i`, and not earlier.
- R5: `offset_o` is the number of clock samples from the first of those reference edges to the first evaluation edge before the second one. An evaluation edge is an edge of `fe_i` leaving the idle level. An evaluation edge on the same sample as the reference edge gives 0. If there is no evaluation edge, the result is 4095.
- R6: `done_o` is 0 in the cycle after `start_i` is sampled low, and `offset_o` keeps its value.
- R7: While `wide_i` is 1, no measurement starts and `done_o` is 0 in the following cycle. The stream strobes keep working.
- R8: After each reference edge, the nominal strobe is high in the cycle that follows the second clock edge after that reference edge, and then every 4 cycles. `strobe_o[s]` is that pulse delayed by the value in `dly_cfg_i[4s+3:4s]`, in cycles. Values above 8 act as 8.
- R9: While `start_i` stays high after completion, `done_o` stays 1 and `offset_o` does not change, even if the evaluation timing moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-step clock, twice the master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | System frame pulse, either polarity |
| fe_i | input | 1 | Frame-evaluation input from the stream under test |
| start_i | input | 1 | Measurement start bit |
| wide_i | input | 1 | Wide-frame mode select; blocks measurement |
| dly_cfg_i | input | 4*NSTREAM | Per-stream strobe delay, 4 bits per stream |
| done_o | output | 1 | Measurement complete |
| offset_o | output | 12 | Measured offset in half-clock steps |
| gci_o | output | 1 | 1 when the frame pulse is active-high |
| strobe_o | output | NSTREAM | Delayed sampling strobe per stream |

## Verification
Measurements are run with the evaluation edge placed at several positions. One sits on the reference sample itself. One sits one step after it. Others sit in mid-frame and on the last sample before the closing reference edge. One run has no edge at all. Together these separate an off-by-one count, a missed coincident edge and a missing saturation value. The same positions are repeated under both frame-pulse polarities, which shows whether edge selection follows the detected format. Directed runs cover a start rise that was never armed, a start held high after completion, a start blocked by wide mode, and a strobe sweep with zero, mid, maximum and over-range delays.

// File: rtl/frame_offset_pkg.sv
package frame_offset_pkg;
  localparam int OFS_W = 12;
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_WAIT = 2'd1,
    MS_MEAS = 2'd2,
    MS_DONE = 2'd3
  } meas_state_e;
endpackage

// File: rtl/fp_polarity.sv
module fp_polarity #(
  parameter int IDLE_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_i,
  input  logic fe_i,
  output logic gci_o,
  output logic ref_edge_o,
  output logic eval_edge_o
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_RUN - 1);

  logic             fp_q, fe_q, idle_q;
  logic             idle_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             same;

  always_comb begin
    same   = (fp_i == fp_q);
    run_d  = run_q;
    idle_d = idle_q;
    if (!same) begin
      run_d = '0;
    end else if (run_q != RUN_LAST) begin
      run_d = run_q + 1'b1;
    end
    if (same && (run_q == RUN_LAST)) begin
      idle_d = fp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q   <= 1'b1;
      fe_q   <= 1'b1;
      idle_q <= 1'b1;
      run_q  <= '0;
    end else begin
      fp_q   <= fp_i;
      fe_q   <= fe_i;
      idle_q <= idle_d;
      run_q  <= run_d;
    end
  end

  assign gci_o       = ~idle_q;
  assign ref_edge_o  = (fp_q == idle_q) && (fp_i != idle_q);
  assign eval_edge_o = (fe_q == idle_q) && (fe_i != idle_q);
endmodule

// File: rtl/offset_meter.sv
module offset_meter
  import frame_offset_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             eval_edge,
  input  logic             start_i,
  input  logic             wide_i,
  output logic             done_o,
  output logic [OFS_W-1:0] offset_o
);
  localparam logic [OFS_W-1:0] CNT_MAX = '1;

  meas_state_e      state_q, state_d;
  logic             start_q;
  logic [1:0]       low_q, low_d;
  logic [OFS_W-1:0] cnt_q, cnt_d, cap_q, cap_d, ofs_q, ofs_d;
  logic             got_q, got_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    cap_d   = cap_q;
    got_d   = got_q;
    done_d  = done_q;
    ofs_d   = ofs_q;
    low_d   = low_q;
    if (start_i) begin
      low_d = 2'd0;
    end else if (ref_edge && (low_q != 2'd2)) begin
      low_d = low_q + 2'd1;
    end
    case (state_q)
      MS_IDLE: begin
        if (start_i && !start_q && (low_q == 2'd2) && !wide_i) begin
          state_d = MS_WAIT;
        end
      end
      MS_WAIT: begin
        if (ref_edge) begin
          state_d = MS_MEAS;
          cnt_d   = {{(OFS_W-1){1'b0}}, 1'b1};
          cap_d   = '0;
          got_d   = eval_edge;
        end
      end
      MS_MEAS: begin
        if (ref_edge) begin
          state_d = MS_DONE;
          done_d  = 1'b1;
          ofs_d   = got_q ? cap_q : CNT_MAX;
        end else if (eval_edge && !got_q) begin
          got_d = 1'b1;
          cap_d = cnt_q;
        end
      end
      default: ;
    endcase
    if (!start_i || wide_i) begin
      state_d = MS_IDLE;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      start_q <= 1'b0;
      low_q   <= 2'd0;
      cnt_q   <= '0;
      cap_q   <= '0;
      got_q   <= 1'b0;
      done_q  <= 1'b0;
      ofs_q   <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_i;
      low_q   <= low_d;
      cnt_q   <= cnt_d;
      cap_q   <= cap_d;
      got_q   <= got_d;
      done_q  <= done_d;
      ofs_q   <= ofs_d;
    end
  end

  assign done_o   = done_q;
  assign offset_o = ofs_q;
endmodule

// File: rtl/strobe_delay.sv
module strobe_delay #(
  parameter int NSTREAM  = 4,
  parameter int BIT_STEP = 4,
  parameter int MAX_DLY  = 8,
  parameter int SEL_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_edge,
  input  logic [NSTREAM*SEL_W-1:0] cfg_i,
  output logic [NSTREAM-1:0]       strobe_o
);
  localparam int PH_W = $clog2(BIT_STEP);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_STEP - 1);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_DLY);

  logic [PH_W-1:0]    ph_q, ph_d;
  logic [MAX_DLY-1:0] dly_q, dly_d;
  logic               nom;
  logic [MAX_DLY:0]   taps;

  always_comb begin
    if (ref_edge) begin
      ph_d = PH_W'(1);
    end else if (ph_q == PH_LAST) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + 1'b1;
    end
    nom   = (ph_q == PH_LAST);
    dly_d = {dly_q[MAX_DLY-2:0], nom};
    taps  = {dly_q, nom};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      dly_q <= '0;
    end else begin
      ph_q  <= ph_d;
      dly_q <= dly_d;
    end
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
    logic [SEL_W-1:0] sel, eff;
    always_comb begin
      sel         = cfg_i[s*SEL_W +: SEL_W];
      eff         = (sel > SEL_MAX) ? SEL_MAX : sel;
      strobe_o[s] = taps[eff];
    end
  end
endmodule

// File: rtl/frame_offset_unit.sv
module frame_offset_unit
  import frame_offset_pkg::*;
#(
  parameter int NSTREAM  = 4,
  parameter int IDLE_RUN = 8,
  parameter int BIT_STEP = 4,
  parameter int MAX_DLY  = 8,
  parameter int SEL_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fp_i,
  input  logic                     fe_i,
  input  logic                     start_i,
  input  logic                     wide_i,
  input  logic [NSTREAM*SEL_W-1:0] dly_cfg_i,
  output logic                     done_o,
  output logic [OFS_W-1:0]         offset_o,
  output logic                     gci_o,
  output logic [NSTREAM-1:0]       strobe_o
);
  logic rst_meta, rst_sync_n;
  logic ref_edge, eval_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fp_polarity #(.IDLE_RUN(IDLE_RUN)) u_pol (
    .clk(clk), .rst_n(rst_sync_n), .fp_i(fp_i), .fe_i(fe_i),
    .gci_o(gci_o), .ref_edge_o(ref_edge), .eval_edge_o(eval_edge)
  );

  offset_meter u_meter (
    .clk(clk), .rst_n(rst_sync_n), .ref_edge(ref_edge), .eval_edge(eval_edge),
    .start_i(start_i), .wide_i(wide_i), .done_o(done_o), .offset_o(offset_o)
  );

  strobe_delay #(
    .NSTREAM(NSTREAM), .BIT_STEP(BIT_STEP), .MAX_DLY(MAX_DLY), .SEL_W(SEL_W)
  ) u_strobe (
    .clk(clk), .rst_n(rst_sync_n), .ref_edge(ref_edge),
    .cfg_i(dly_cfg_i), .strobe_o(strobe_o)
  );
endmodule

// File: rtl/frame_offset_chk.sv
module frame_offset_chk #(
  parameter int OW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fp_i,
  input logic          ref_edge,
  input logic          start_i,
  input logic          wide_i,
  input logic          done_o,
  input logic          gci_o,
  input logic [OW-1:0] offset_o
);
  a_r4_done_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(ref_edge));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  a_r7_wide_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wide_i |=> !done_o);

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i && !wide_i) |=> $stable(offset_o));

  a_r2_format_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gci_o) |-> ($past(fp_i) == $past(fp_i, 2)));
endmodule

bind frame_offset_unit frame_offset_chk #(.OW(frame_offset_pkg::OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .fp_i(fp_i), .ref_edge(ref_edge),
  .start_i(start_i), .wide_i(wide_i), .done_o(done_o), .gci_o(gci_o),
  .offset_o(offset_o)
);

// File: tb/test_frame_offset_unit.sv
module test_frame_offset_unit;
  localparam int NS  = 4;
  localparam int FRM = 40;
  localparam int NV  = 6;
  localparam int V_GCI [NV] = '{0, 0, 1, 1, 0, 1};
  localparam int V_FE  [NV] = '{5, 0, 17, 39, 120, 1};
  localparam int V_EXP [NV] = '{5, 0, 17, 39, 4095, 1};

  logic clk = 1'b0;
  logic rst_n, fp_i, fe_i, start_i, wide_i;
  logic [NS*4-1:0] dly_cfg_i;
  logic done_o, gci_o;
  logic [11:0] offset_o;
  logic [NS-1:0] strobe_o;

  int n_chk = 0, n_bad = 0;
  int fcnt = FRM - 1;
  int gci_mode = 0;
  int fe_pos = 200;

  always #2 clk = ~clk;

  frame_offset_unit #(.NSTREAM(NS)) i_frame_offset_unit (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .fe_i(fe_i), .start_i(start_i),
    .wide_i(wide_i), .dly_cfg_i(dly_cfg_i), .done_o(done_o),
    .offset_o(offset_o), .gci_o(gci_o), .strobe_o(strobe_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // frame pulse and evaluation generator, updated on falling edges
  initial begin
    fp_i = 1'b1;
    fe_i = 1'b1;
    forever begin
      @(negedge clk);
      fcnt = (fcnt + 1) % FRM;
      fp_i = (fcnt == 0) ? (gci_mode != 0) : (gci_mode == 0);
      fe_i = ((fcnt == fe_pos) || (fcnt == fe_pos + 1)) ? (gci_mode != 0) : (gci_mode == 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic sync_mid();
    do @(posedge clk); while (fcnt != 10);
    @(negedge clk);
  endtask

  task automatic measure(input int gci, input int pos, input int exp);
    @(negedge clk);
    gci_mode = gci;
    fe_pos   = pos;
    start_i  = 1'b0;
    repeat (3 * FRM) @(posedge clk);
    @(negedge clk);
    chk("R6 done low while armed", int'(done_o), 0);
    sync_mid();
    start_i = 1'b1;
    repeat (69) @(posedge clk);
    @(negedge clk);
    chk("R4 not yet done", int'(done_o), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 done after second reference", int'(done_o), 1);
    chk("R5 offset", int'(offset_o), exp);
    chk("R2 format", int'(gci_o), gci);
  endtask

  initial begin
    int held;
    rst_n = 1'b0; start_i = 1'b0; wide_i = 1'b0;
    dly_cfg_i = {4'd12, 4'd8, 4'd3, 4'd0};
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 offset in reset", int'(offset_o), 0);
    chk("R1 format in reset", int'(gci_o), 0);
    chk("R1 strobes in reset", int'(strobe_o), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 done after release", int'(done_o), 0);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R2 active-low detected", int'(gci_o), 0);

    for (int v = 0; v < NV; v++) measure(V_GCI[v], V_FE[v], V_EXP[v]);

    // R9: start held high, evaluation moves, result unchanged
    held = int'(offset_o);
    fe_pos = 3;
    repeat (2 * FRM) @(posedge clk);
    @(negedge clk);
    chk("R9 done held", int'(done_o), 1);
    chk("R9 offset held", int'(offset_o), held);

    // R6: start low clears done next cycle
    start_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6 done cleared", int'(done_o), 0);
    chk("R6 offset kept", int'(offset_o), held);

    // R3: rise without a full low frame is ignored
    start_i = 1'b1;
    repeat (3 * FRM) @(posedge clk);
    @(negedge clk);
    chk("R3 unarmed start ignored", int'(done_o), 0);

    // R7: wide mode blocks measurement
    start_i = 1'b0;
    wide_i  = 1'b1;
    repeat (3 * FRM) @(posedge clk);
    sync_mid();
    start_i = 1'b1;
    repeat (3 * FRM) @(posedge clk);
    @(negedge clk);
    chk("R7 wide blocks measurement", int'(done_o), 0);

    // R8: strobe delays, still active in wide mode (R7)
    do @(posedge clk); while (fcnt != 0);
    for (int k = 0; k < 12; k++) begin
      logic [NS-1:0] exp_s;
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
        int d;
        d = int'(dly_cfg_i[s*4 +: 4]);
        if (d > 8) d = 8;
        exp_s[s] = (((k + FRM - 2 - d) % 4) == 0);
      end
      chk("R8 stream strobes (R7 wide)", int'(strobe_o), int'(exp_s));
      @(posedge clk);
    end
    finish_run();
  end
endmodule